// File: doc/BRIEF.md
# Charge-Path Protection Sequencer

This block decides when the charge switch of a two-cell lithium-ion pack may conduct. It receives comparator flags for both cells, a load-present flag, a flag for a charger whose voltage is too high, a flag that asks for charging of fully depleted cells, and the present state of the discharge switch. It drives a single charge-enable output. The output is high when charging is allowed.

Two trip conditions can open the charge switch. One is a cell overvoltage. The other is an excessive-voltage charger. Each trip needs its condition to hold for a counted number of clock cycles before it takes effect. Each clears only after its release condition has held for a counted number of cycles. The threshold used for overvoltage release depends on whether a load is connected. A test input divides every counted delay by a power of two so that production test runs faster.

Top module: `chg_guard`

## Requirements
- R1: After reset, and after any reset asserted later, `chg_en` is 1 and both trip states are clear.
- R2: If `ov_a` or `ov_b` is 1 on `DET_OV_CYC` consecutive rising edges, `chg_en` goes to 0 right after the last of those edges. One edge fewer leaves it at 1.
- R3: If the overvoltage condition drops before its count completes, the detection count restarts from zero.
- R4: While overcharge-tripped with `load_on`=0, release requires `rel_lo_a` and `rel_lo_b` both at 1 for `REL_OV_CYC` consecutive edges. If only one cell qualifies, the block stays tripped.
- R5: While overcharge-tripped with `load_on`=1, release uses `rel_hi_a` and `rel_hi_b` both at 1 for `REL_OV_CYC` consecutive edges instead.
- R6: If `xchg` and `dis_en` are both 1 on `DET_X_CYC` consecutive edges, `chg_en` goes to 0. If `xchg` drops earlier, the detection is abandoned and its count restarts.
- R7: After an excessive-charger trip, `chg_en` returns to 1 once `xchg` has been 0 for `REL_X_CYC` consecutive edges, provided no overvoltage trip is active.
- R8: While `dis_en`=0, `xchg` has no effect. The detection delay starts counting only from the first edge where `dis_en` is 1.
- R9: Excessive-charger detection also runs during an overvoltage trip. If `xchg` is present when the overvoltage trip releases, `chg_en` stays 0 throughout, with no high pulse.
- R10: While `zvc_en`=1, `chg_en` is 1 regardless of trip state. The trip states themselves are kept unchanged.
- R11: While `fast_mode`=1, each delay becomes its nominal count shifted right by `FAST_SHIFT`, with a minimum of 1. With the default parameters this gives 10 edges for overvoltage detection and 4 for its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ov_a | input | 1 | Cell A at or above the overvoltage threshold |
| ov_b | input | 1 | Cell B at or above the overvoltage threshold |
| rel_lo_a | input | 1 | Cell A at or below the low release threshold (used when no load is present) |
| rel_lo_b | input | 1 | Cell B at or below the low release threshold |
| rel_hi_a | input | 1 | Cell A at or below the high release threshold (used when a load is present) |
| rel_hi_b | input | 1 | Cell B at or below the high release threshold |
| load_on | input | 1 | A load is present (return node above the overcurrent level) |
| xchg | input | 1 | Excessive-voltage charger sensed |
| zvc_en | input | 1 | Charging of depleted cells requested; forces charging on |
| dis_en | input | 1 | Discharge switch currently on |
| fast_mode | input | 1 | Shortened-delay test mode |
| chg_en | output | 1 | Charge switch enable, 1 = charging allowed |

## Verification
The checks assume consistent comparator flags. A cell flagged as overvoltage is never also flagged below either release threshold. A cell below the low release threshold is also below the high one. The bench vectors are built only from cell states that meet these rules: normal, between the two thresholds, or over the limit. The excessive-charger checks assume that `xchg` and `dis_en` are sampled on the clock, with no timing relation between them. The stimulus therefore changes them only on falling edges.

// File: rtl/cg_pkg.sv
package cg_pkg;

  typedef enum logic {
    GUARD_OPEN = 1'b0,
    GUARD_TRIP = 1'b1
  } trip_e;

  function automatic int unsigned short_dly(int unsigned base, int unsigned sh);
    int unsigned v;
    v = base >> sh;
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/cg_delay.sv
module cg_delay #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] lim,
  output logic         done
);

  logic [W-1:0] cnt_q, cnt_d;

  // lim is at least 1; >= covers a limit that shrinks mid-count
  assign done = run && (cnt_q >= (lim - W'(1)));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || done) cnt_d = '0;
    else              cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: a dropped qualifying condition leaves the count at zero
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/cg_ochg.sv
module cg_ochg
  import cg_pkg::*;
#(
  parameter int unsigned DET_CYC = 40,
  parameter int unsigned REL_CYC = 16,
  parameter int unsigned SHIFT   = 2,
  parameter int unsigned W       = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ov_a,
  input  logic ov_b,
  input  logic rel_lo_a,
  input  logic rel_lo_b,
  input  logic rel_hi_a,
  input  logic rel_hi_b,
  input  logic load_on,
  input  logic fast_mode,
  output logic tripped
);

  localparam logic [W-1:0] DET_FULL  = W'(DET_CYC);
  localparam logic [W-1:0] REL_FULL  = W'(REL_CYC);
  localparam logic [W-1:0] DET_SHORT = W'(short_dly(DET_CYC, SHIFT));
  localparam logic [W-1:0] REL_SHORT = W'(short_dly(REL_CYC, SHIFT));

  trip_e        st_q, st_d;
  logic         any_ov, rel_ok, run, done;
  logic [W-1:0] lim;

  assign any_ov = ov_a | ov_b;
  assign rel_ok = load_on ? (rel_hi_a & rel_hi_b) : (rel_lo_a & rel_lo_b);

  always_comb begin
    if (st_q == GUARD_OPEN) begin
      run = any_ov;
      lim = fast_mode ? DET_SHORT : DET_FULL;
    end else begin
      run = rel_ok;
      lim = fast_mode ? REL_SHORT : REL_FULL;
    end
  end

  cg_delay #(.W(W)) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .lim  (lim),
    .done (done)
  );

  always_comb begin
    st_d = st_q;
    if (done) st_d = (st_q == GUARD_OPEN) ? GUARD_TRIP : GUARD_OPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GUARD_OPEN;
    else        st_q <= st_d;
  end

  assign tripped = (st_q == GUARD_TRIP);

  p_trip_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripped) |-> $past(ov_a | ov_b));

  // R4 / R5: release only on the threshold picked by the load flag
  p_release_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tripped) |-> $past(load_on ? (rel_hi_a & rel_hi_b) : (rel_lo_a & rel_lo_b)));

endmodule

// File: rtl/cg_xchg.sv
module cg_xchg
  import cg_pkg::*;
#(
  parameter int unsigned DET_CYC = 8,
  parameter int unsigned REL_CYC = 8,
  parameter int unsigned SHIFT   = 2,
  parameter int unsigned W       = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xchg,
  input  logic dis_en,
  input  logic fast_mode,
  output logic tripped
);

  localparam logic [W-1:0] DET_FULL  = W'(DET_CYC);
  localparam logic [W-1:0] REL_FULL  = W'(REL_CYC);
  localparam logic [W-1:0] DET_SHORT = W'(short_dly(DET_CYC, SHIFT));
  localparam logic [W-1:0] REL_SHORT = W'(short_dly(REL_CYC, SHIFT));

  trip_e        st_q, st_d;
  logic         run, done;
  logic [W-1:0] lim;

  always_comb begin
    if (st_q == GUARD_OPEN) begin
      run = xchg & dis_en;
      lim = fast_mode ? DET_SHORT : DET_FULL;
    end else begin
      run = ~xchg;
      lim = fast_mode ? REL_SHORT : REL_FULL;
    end
  end

  cg_delay #(.W(W)) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .lim  (lim),
    .done (done)
  );

  always_comb begin
    st_d = st_q;
    if (done) st_d = (st_q == GUARD_OPEN) ? GUARD_TRIP : GUARD_OPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GUARD_OPEN;
    else        st_q <= st_d;
  end

  assign tripped = (st_q == GUARD_TRIP);

  p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripped) |-> $past(dis_en & xchg));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tripped) |-> $past(!xchg));

endmodule

// File: rtl/chg_guard.sv
module chg_guard #(
  parameter int unsigned DET_OV_CYC = 40,
  parameter int unsigned REL_OV_CYC = 16,
  parameter int unsigned DET_X_CYC  = 8,
  parameter int unsigned REL_X_CYC  = 8,
  parameter int unsigned FAST_SHIFT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ov_a,
  input  logic ov_b,
  input  logic rel_lo_a,
  input  logic rel_lo_b,
  input  logic rel_hi_a,
  input  logic rel_hi_b,
  input  logic load_on,
  input  logic xchg,
  input  logic zvc_en,
  input  logic dis_en,
  input  logic fast_mode,
  output logic chg_en
);

  localparam int unsigned OV_MAX = (DET_OV_CYC > REL_OV_CYC) ? DET_OV_CYC : REL_OV_CYC;
  localparam int unsigned X_MAX  = (DET_X_CYC > REL_X_CYC) ? DET_X_CYC : REL_X_CYC;
  localparam int unsigned OV_W   = $clog2(OV_MAX + 1);
  localparam int unsigned X_W    = $clog2(X_MAX + 1);

  logic ov_trip, x_trip;

  cg_ochg #(
    .DET_CYC(DET_OV_CYC),
    .REL_CYC(REL_OV_CYC),
    .SHIFT  (FAST_SHIFT),
    .W      (OV_W)
  ) u_ochg (
    .clk      (clk),
    .rst_n    (rst_n),
    .ov_a     (ov_a),
    .ov_b     (ov_b),
    .rel_lo_a (rel_lo_a),
    .rel_lo_b (rel_lo_b),
    .rel_hi_a (rel_hi_a),
    .rel_hi_b (rel_hi_b),
    .load_on  (load_on),
    .fast_mode(fast_mode),
    .tripped  (ov_trip)
  );

  cg_xchg #(
    .DET_CYC(DET_X_CYC),
    .REL_CYC(REL_X_CYC),
    .SHIFT  (FAST_SHIFT),
    .W      (X_W)
  ) u_xchg (
    .clk      (clk),
    .rst_n    (rst_n),
    .xchg     (xchg),
    .dis_en   (dis_en),
    .fast_mode(fast_mode),
    .tripped  (x_trip)
  );

  assign chg_en = zvc_en | ~(ov_trip | x_trip);

  // R9: when overvoltage releases with the charger still excessive, no high pulse
  p_no_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ov_trip) && $past(xchg) && $past(dis_en) && $past(x_trip) && !zvc_en) |-> !chg_en);

endmodule

// File: tb/sim_chg_guard.sv
module sim_chg_guard;

  logic clk = 1'b0;
  logic rst_n;
  logic ov_a, ov_b, rel_lo_a, rel_lo_b, rel_hi_a, rel_hi_b;
  logic load_on, xchg, zvc_en, dis_en, fast_mode;
  logic chg_en;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  chg_guard u0 (
    .clk(clk), .rst_n(rst_n),
    .ov_a(ov_a), .ov_b(ov_b),
    .rel_lo_a(rel_lo_a), .rel_lo_b(rel_lo_b),
    .rel_hi_a(rel_hi_a), .rel_hi_b(rel_hi_b),
    .load_on(load_on), .xchg(xchg), .zvc_en(zvc_en),
    .dis_en(dis_en), .fast_mode(fast_mode),
    .chg_en(chg_en)
  );

  // input bits: [10]fast [9]zvc [8]dis [7]xchg [6]load [5]hi_b [4]hi_a [3]lo_b [2]lo_a [1]ov_b [0]ov_a
  // row: {req[3:0], expected chg_en, edges[7:0], inputs[10:0]}
  localparam int NV = 31;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1,  1'b1, 8'd5,  11'h13C},  // R1 normal cells
    {4'd3,  1'b1, 8'd20, 11'h129},  // R3 partial overvoltage on cell A
    {4'd3,  1'b1, 8'd3,  11'h13C},  // R3 drop restarts count
    {4'd2,  1'b1, 8'd39, 11'h129},  // R2 one short of the delay
    {4'd2,  1'b0, 8'd1,  11'h129},  // R2 trip
    {4'd4,  1'b0, 8'd30, 11'h138},  // R4 cell A between thresholds, no load
    {4'd4,  1'b0, 8'd15, 11'h13C},  // R4 both low, one short
    {4'd4,  1'b1, 8'd1,  11'h13C},  // R4 release
    {4'd2,  1'b1, 8'd39, 11'h116},  // R2 cell B
    {4'd2,  1'b0, 8'd1,  11'h116},  // R2 cell B trip
    {4'd5,  1'b0, 8'd15, 11'h178},  // R5 load present, high threshold
    {4'd5,  1'b1, 8'd1,  11'h178},  // R5 release
    {4'd6,  1'b1, 8'd7,  11'h1BC},  // R6 excessive charger, short of delay
    {4'd6,  1'b1, 8'd2,  11'h13C},  // R6 abandoned
    {4'd6,  1'b1, 8'd7,  11'h1BC},  // R6 restart, short of delay
    {4'd6,  1'b0, 8'd1,  11'h1BC},  // R6 trip
    {4'd7,  1'b0, 8'd7,  11'h13C},  // R7 clear, one short
    {4'd7,  1'b1, 8'd1,  11'h13C},  // R7 release
    {4'd8,  1'b1, 8'd20, 11'h0BC},  // R8 discharge off, flag ignored
    {4'd8,  1'b1, 8'd7,  11'h1BC},  // R8 delay starts after discharge on
    {4'd8,  1'b0, 8'd1,  11'h1BC},  // R8 trip
    {4'd7,  1'b1, 8'd8,  11'h13C},  // R7 release
    {4'd2,  1'b0, 8'd40, 11'h129},  // R2 trip again
    {4'd10, 1'b1, 8'd2,  11'h329},  // R10 forced on
    {4'd10, 1'b0, 8'd1,  11'h329 & 11'h1FF}, // R10 trip state kept
    {4'd9,  1'b0, 8'd16, 11'h1BC},  // R9 release with excessive charger
    {4'd9,  1'b0, 8'd20, 11'h1BC},  // R9 still low
    {4'd9,  1'b1, 8'd8,  11'h13C},  // R9 charger normal, high again
    {4'd11, 1'b1, 8'd9,  11'h529},  // R11 fast detect, one short
    {4'd11, 1'b0, 8'd1,  11'h529},  // R11 fast trip at 10
    {4'd11, 1'b0, 8'd3,  11'h53C}   // R11 fast release one short
  };

  task automatic apply(input logic [10:0] v);
    {fast_mode, zvc_en, dis_en, xchg, load_on, rel_hi_b, rel_hi_a,
     rel_lo_b, rel_lo_a, ov_b, ov_a} = v;
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input int req, input int row);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d row %0d: chg_en=%b expected %b", req, row, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    apply(11'h13C);
    repeat (3) @(negedge clk);
    check(chg_en, 1'b1, 1, -1);  // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][10:0]);
      hold(int'(VEC[i][18:11]));
      check(chg_en, VEC[i][19], int'(VEC[i][23:20]), i);
    end
    // R11: final fast release edge
    apply(11'h53C);
    hold(1);
    check(chg_en, 1'b1, 11, 100);
    // R1: reset while tripped
    apply(11'h129);
    hold(40);
    check(chg_en, 1'b0, 2, 101);
    rst_n = 1'b0;
    @(negedge clk);
    check(chg_en, 1'b1, 1, 102);
    rst_n = 1'b1;
    apply(11'h13C);
    hold(2);
    check(chg_en, 1'b1, 1, 103);
    // R4: no load, only cell B low -> stays tripped
    apply(11'h129);
    hold(40);
    apply(11'h138);
    hold(40);
    check(chg_en, 1'b0, 4, 104);
    // R10: forced on while excessive charger also tripped
    apply(11'h3B8);
    hold(10);
    check(chg_en, 1'b1, 10, 105);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule